// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block decides when a subscriber line controller stops its main oscillator and when it starts it again. Software asks for the low-power state by writing the power-down code into the mode field of a global configuration word. The controller stops the oscillator on the transition into that code. While the oscillator is stopped, the controller watches three wake sources: an activation event from the line interface, a falling request line from a slave device when the serial bus is clock master, and a rising serial clock when the serial bus is clock slave. A source wakes the device only when both the global interrupt output and that source's own enable are set.

On a qualified wake the oscillator restarts at once. The active-low interrupt output is held back until a fixed number of main-clock cycles have been produced. The line interface may restart the oscillator on its own to examine line activity. If it then classifies that activity as noise, the oscillator stops again and no interrupt is raised. The selected main-clock frequency is held across the low-power period, and only reset returns it to the default.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, osc_run is 1, int_n is 1 and freq_sel is 0 (the 6.144 MHz default), whatever the configuration word holds.
- R2: The oscillator stops (osc_run falls) on the first clock edge at which cfg[1:0] equals 2'b11 after having held another value on the previous edge. A mode field that stays at 2'b11 after a wake does not stop the oscillator again.
- R3: A rising edge on act_event while stopped wakes the device on that clock edge only when cfg[2] is 0 (interrupt output enabled) and ien_act is 1. Otherwise the device stays stopped.
- R4: With bus_master at 1, a falling edge on sreq_n wakes the device three clock edges after it is applied, through a two-stage synchroniser. This needs cfg[2] at 0 and ien_bus at 1. sclk_in is ignored in this case.
- R5: With bus_master at 0, a rising edge on sclk_in wakes the device three clock edges after it is applied, under the same two enables. sreq_n is ignored in this case.
- R6: A wake-source level that is already present when the stop is entered causes no wake. Only a new edge does.
- R7: After a wake, osc_run is 1 from the next clock edge on. int_n falls only at the edge where the second mclk_tick of the restart is counted.
- R8: While stopped, line_probe restarts the oscillator and holds it running. line_noise then stops it again, without raising int_n and without returning to the running state.
- R9: int_n is 1 whenever the oscillator is stopped or cfg[2] is 1. A pending interrupt is cleared by int_ack.
- R10: freq_sel encodes cfg[5:3] as 001→1 (12.288 MHz), 010→2 (3.072 MHz), 100→3 (4.096 MHz) and every other code →0 (6.144 MHz). It follows cfg one edge late while running and holds its value from the stop until the wake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg | input | 8 | Configuration word: [1:0] mode, [2] interrupt output disable, [5:3] frequency code |
| ien_act | input | 1 | Enable for the line activation wake |
| ien_bus | input | 1 | Enable for the serial-bus timing-request wakes |
| bus_master | input | 1 | 1: serial bus is clock master, 0: clock slave |
| act_event | input | 1 | Line interface reached its activated state (synchronous level) |
| sreq_n | input | 1 | Slave request line, asynchronous, active low |
| sclk_in | input | 1 | Incoming serial clock, asynchronous |
| line_probe | input | 1 | Line interface asks for the oscillator to examine activity |
| line_noise | input | 1 | Line interface classified the activity as noise |
| mclk_tick | input | 1 | One main-clock cycle has been produced |
| int_ack | input | 1 | Clears the pending wake interrupt |
| osc_run | output | 1 | Main oscillator enable |
| int_n | output | 1 | Interrupt output, active low |
| freq_sel | output | 2 | Effective main-clock frequency code |

## Verification
Mode entry, act_event, line_probe and line_noise act on the next clock edge. sreq_n and sclk_in take three edges because of the synchroniser and the edge register. int_n depends on cfg[2] without a register, and freq_sel lags cfg by one edge. A behavioural model in the bench keeps its own input history and state and is compared with every output one nanosecond after each rising edge. The directed checks drive inputs on falling edges and read outputs on the next falling edge, counting the stated latency, including the cycles at which a wake must not yet be visible.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STOP  = 2'd1,
    ST_PROBE = 2'd2,
    ST_WARM  = 2'd3
  } pw_state_e;

  typedef enum logic [1:0] {
    FQ_6144  = 2'd0,
    FQ_12288 = 2'd1,
    FQ_3072  = 2'd2,
    FQ_4096  = 2'd3
  } mclk_freq_e;

  localparam logic [1:0] MODE_STOP = 2'b11;
  localparam int CFG_IDIS_BIT = 2;
  localparam int CFG_FREQ_LSB = 3;
  localparam int CFG_FREQ_W   = 3;

  function automatic mclk_freq_e freq_decode(input logic [CFG_FREQ_W-1:0] code);
    case (code)
      3'b001:  freq_decode = FQ_12288;
      3'b010:  freq_decode = FQ_3072;
      3'b100:  freq_decode = FQ_4096;
      default: freq_decode = FQ_6144;
    endcase
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= 1'b1;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_wake_edge.sv
module pwr_wake_edge #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_VAL     = 1'b0,
  parameter bit DETECT_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic lvl;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = din;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= {SYNC_STAGES{RST_VAL}};
        end else begin
          pipe_q[0] <= din;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            pipe_q[i] <= pipe_q[i-1];
          end
        end
      end
      assign lvl = pipe_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  generate
    if (DETECT_FALL) begin : g_fall
      assign edge_o = prev_q & ~lvl;
    end else begin : g_rise
      assign edge_o = ~prev_q & lvl;
    end
  endgenerate

endmodule

// File: rtl/pwr_wake_fsm.sv
module pwr_wake_fsm
  import pwr_wake_pkg::*;
#(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic probe,
  input  logic noise,
  input  logic tick,
  input  logic ack,
  output logic osc_run_o,
  output logic run_o,
  output logic int_pend_o
);

  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

  pw_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pend_q, pend_d;
  logic req_prev_q;
  logic stop_edge;

  assign stop_edge = stop_req & ~req_prev_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q & ~ack;
    case (state_q)
      ST_RUN: begin
        if (stop_edge) begin
          state_d = ST_STOP;
          pend_d  = 1'b0;
        end
      end
      ST_STOP: begin
        if (wake) begin
          state_d = ST_WARM;
          cnt_d   = '0;
        end else if (probe) begin
          state_d = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (wake) begin
          state_d = ST_WARM;
          cnt_d   = '0;
        end else if (noise) begin
          state_d = ST_STOP;
        end
      end
      ST_WARM: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            state_d = ST_RUN;
            pend_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      pend_q     <= pend_d;
      req_prev_q <= stop_req;
    end
  end

  assign osc_run_o  = (state_q != ST_STOP);
  assign run_o      = (state_q == ST_RUN);
  assign int_pend_o = pend_q;

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WARM) |-> (cnt_q < CNT_W'(WAKE_CYC)));

  assert_pend_after_warm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(state_q) == ST_WARM));

  assert_noise_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROBE && noise && !wake) |=> (!osc_run_o && !pend_q));

  assert_stop_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_run_o) |-> ($past(stop_req) || $past(noise)));

endmodule

// File: rtl/pwr_freq_hold.sv
module pwr_freq_hold
  import pwr_wake_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [CFG_FREQ_W-1:0] code,
  output logic [1:0]            freq_o
);

  mclk_freq_e freq_q, freq_d;

  assign freq_d = freq_decode(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      freq_q <= FQ_6144;
    else if (upd_en) freq_q <= freq_d;
  end

  assign freq_o = freq_q;

  assert_freq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(freq_q));

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int WAKE_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       ien_act,
  input  logic       ien_bus,
  input  logic       bus_master,
  input  logic       act_event,
  input  logic       sreq_n,
  input  logic       sclk_in,
  input  logic       line_probe,
  input  logic       line_noise,
  input  logic       mclk_tick,
  input  logic       int_ack,
  output logic       osc_run,
  output logic       int_n,
  output logic [1:0] freq_sel
);

  logic rst_i_n;
  logic act_rise, sreq_fall, sclk_rise;
  logic bus_evt, int_en, stop_req, wake;
  logic run, int_pend;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  pwr_wake_edge #(.SYNC_STAGES(0), .RST_VAL(1'b0), .DETECT_FALL(1'b0)) u_act_edge (
    .clk(clk), .rst_n(rst_i_n), .din(act_event), .edge_o(act_rise)
  );

  pwr_wake_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_FALL(1'b1)) u_sreq_edge (
    .clk(clk), .rst_n(rst_i_n), .din(sreq_n), .edge_o(sreq_fall)
  );

  pwr_wake_edge #(.SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_FALL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_i_n), .din(sclk_in), .edge_o(sclk_rise)
  );

  assign int_en   = ~cfg[CFG_IDIS_BIT];
  assign stop_req = (cfg[1:0] == MODE_STOP);
  assign bus_evt  = bus_master ? sreq_fall : sclk_rise;
  assign wake     = int_en & ((act_rise & ien_act) | (bus_evt & ien_bus));

  pwr_wake_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .stop_req(stop_req), .wake(wake), .probe(line_probe), .noise(line_noise),
    .tick(mclk_tick), .ack(int_ack),
    .osc_run_o(osc_run), .run_o(run), .int_pend_o(int_pend)
  );

  pwr_freq_hold u_freq (
    .clk(clk), .rst_n(rst_i_n), .upd_en(run),
    .code(cfg[CFG_FREQ_LSB +: CFG_FREQ_W]), .freq_o(freq_sel)
  );

  assign int_n = ~(int_pend & int_en & osc_run);

  assert_restart_qualified_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(osc_run) |-> ($past(line_probe) || $past(int_en)));

  assert_int_after_clock_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(int_n) |-> $past(osc_run));

  assert_int_quiet_stopped_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!run && !$past(run)) |-> int_n);

endmodule

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg;
  logic ien_act, ien_bus, bus_master, act_event, sreq_n, sclk_in;
  logic line_probe, line_noise, mclk_tick, int_ack;
  logic osc_run, int_n;
  logic [1:0] freq_sel;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ien_act(ien_act), .ien_bus(ien_bus),
    .bus_master(bus_master), .act_event(act_event), .sreq_n(sreq_n), .sclk_in(sclk_in),
    .line_probe(line_probe), .line_noise(line_noise), .mclk_tick(mclk_tick),
    .int_ack(int_ack), .osc_run(osc_run), .int_n(int_n), .freq_sel(freq_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fdec(input logic [2:0] c);
    case (c)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b100:  return 3;
      default: return 0;
    endcase
  endfunction

  // behavioural reference: 0 run, 1 stopped, 2 probing, 3 warming
  int m_st, m_cnt, m_freq, rcnt;
  bit m_pend, m_act_prev, m_mode_prev;
  bit sq[$];
  bit kq[$];

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_freq = 0; m_pend = 0;
    m_act_prev = 0; m_mode_prev = 0;
    sq = '{1'b1, 1'b1, 1'b1};
    kq = '{1'b0, 1'b0, 1'b0};
  endtask

  always begin
    @(posedge clk);
    #1;
    if (!rst_n) begin
      rcnt = 0;
      m_reset();
    end else if (rcnt < 2) begin
      rcnt++;
      m_reset();
    end else begin
      bit sfall, krise, arise, stop_edge, wk, ien;
      int st_old;
      sfall = sq[$-2] && !sq[$-1];
      krise = !kq[$-2] && kq[$-1];
      sq.push_back(sreq_n); kq.push_back(sclk_in);
      if (sq.size() > 3) void'(sq.pop_front());
      if (kq.size() > 3) void'(kq.pop_front());
      arise = act_event && !m_act_prev;
      m_act_prev = act_event;
      stop_edge = (cfg[1:0] == 2'b11) && !m_mode_prev;
      m_mode_prev = (cfg[1:0] == 2'b11);
      ien = !cfg[2];
      wk = ien && ((arise && ien_act) || ((bus_master ? sfall : krise) && ien_bus));
      st_old = m_st;
      if (int_ack) m_pend = 0;
      if (m_st == 0) begin
        if (stop_edge) begin m_st = 1; m_pend = 0; end
      end else if (m_st == 1 || m_st == 2) begin
        if (wk) begin m_st = 3; m_cnt = 0; end
        else if (m_st == 1 && line_probe) m_st = 2;
        else if (m_st == 2 && line_noise) m_st = 1;
      end else if (mclk_tick) begin
        if (m_cnt == 1) begin m_st = 0; m_pend = 1; end
        else m_cnt++;
      end
      if (st_old == 0) m_freq = fdec(cfg[5:3]);
    end
    chk("R2 osc_run model", int'(osc_run), int'(m_st != 1));
    chk("R7 int_n model", int'(int_n), int'(!(m_pend && !cfg[2] && m_st != 1)));
    chk("R10 freq_sel model", int'(freq_sel), m_freq);
  end

  task automatic nxt(); @(negedge clk); endtask
  task automatic pulse_act(); act_event = 1; nxt(); act_event = 0; endtask
  task automatic two_ticks();
    mclk_tick = 1; nxt(); nxt(); mclk_tick = 0;
  endtask
  task automatic restop();
    cfg[1:0] = 2'b00; nxt(); cfg[1:0] = 2'b11; nxt();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 0; cfg = 8'h00; ien_act = 0; ien_bus = 0; bus_master = 1;
    act_event = 0; sreq_n = 1; sclk_in = 0; line_probe = 0; line_noise = 0;
    mclk_tick = 0; int_ack = 0;
    repeat (3) nxt();
    rst_n = 1;
    repeat (4) nxt();
    chk("R1 osc_run after reset", osc_run, 1);
    chk("R1 int_n after reset", int_n, 1);
    chk("R1 freq_sel after reset", freq_sel, 0);

    cfg = 8'b0000_1000; ien_act = 1; ien_bus = 1; bus_master = 1;
    nxt(); nxt();
    chk("R10 freq code 001", freq_sel, 1);

    // R6: levels already present at entry
    act_event = 1; sreq_n = 0;
    repeat (4) nxt();
    cfg[1:0] = 2'b11; nxt();
    chk("R2 stop on mode entry", osc_run, 0);
    repeat (5) nxt();
    chk("R6 held levels do not wake", osc_run, 0);
    act_event = 0; sreq_n = 1;
    repeat (4) nxt();
    chk("R9 int_n high while stopped", int_n, 1);

    cfg[5:3] = 3'b100;
    pulse_act();
    chk("R3 activation wake", osc_run, 1);
    chk("R10 freq held over stop", freq_sel, 1);
    chk("R7 no int before ticks", int_n, 1);
    mclk_tick = 1; nxt(); mclk_tick = 0;
    chk("R7 no int after one tick", int_n, 1);
    nxt();
    chk("R7 idle cycle no int", int_n, 1);
    mclk_tick = 1; nxt(); mclk_tick = 0;
    chk("R7 int after second tick", int_n, 0);
    nxt();
    chk("R10 freq code 100 after run", freq_sel, 3);

    cfg[2] = 1; nxt();
    chk("R9 int_n masked by disable", int_n, 1);
    cfg[2] = 0; nxt();
    chk("R9 int_n back when enabled", int_n, 0);
    int_ack = 1; nxt(); int_ack = 0;
    chk("R9 ack clears int", int_n, 1);
    repeat (3) nxt();
    chk("R2 held mode no re-entry", osc_run, 1);

    // R3: disabled sources
    cfg[1:0] = 2'b00; nxt();
    cfg[2] = 1; cfg[1:0] = 2'b11; nxt();
    chk("R2 stop again", osc_run, 0);
    pulse_act();
    chk("R3 int output disabled blocks", osc_run, 0);
    cfg[2] = 0; ien_act = 0; nxt();
    pulse_act();
    chk("R3 source enable blocks", osc_run, 0);

    // R4: master mode
    sclk_in = 1; repeat (4) nxt();
    chk("R4 sclk ignored as master", osc_run, 0);
    sclk_in = 0; nxt();
    sreq_n = 0; nxt(); nxt();
    chk("R4 not yet after two edges", osc_run, 0);
    nxt();
    chk("R4 request wake", osc_run, 1);
    sreq_n = 1; two_ticks(); nxt();
    chk("R4 int after request wake", int_n, 0);
    int_ack = 1; nxt(); int_ack = 0;

    // R5: slave mode
    bus_master = 0; restop();
    chk("R5 stopped", osc_run, 0);
    sreq_n = 0; repeat (4) nxt();
    chk("R5 request ignored as slave", osc_run, 0);
    sreq_n = 1; repeat (3) nxt();
    sclk_in = 1; nxt(); nxt();
    chk("R5 not yet after two edges", osc_run, 0);
    nxt();
    chk("R5 clock wake", osc_run, 1);
    sclk_in = 0; two_ticks(); nxt();
    int_ack = 1; nxt(); int_ack = 0;

    // R8: noise
    restop();
    line_probe = 1; nxt(); line_probe = 0;
    chk("R8 probe restarts oscillator", osc_run, 1);
    nxt();
    chk("R8 probe holds oscillator", osc_run, 1);
    line_noise = 1; nxt(); line_noise = 0;
    chk("R8 noise stops oscillator", osc_run, 0);
    chk("R8 noise raises no int", int_n, 1);
    repeat (3) nxt();
    chk("R8 stays stopped", osc_run, 0);
    ien_act = 1;
    line_probe = 1; nxt(); line_probe = 0;
    pulse_act();
    chk("R8 real activity during probe", osc_run, 1);
    two_ticks();
    chk("R3 int after probe wake", int_n, 0);
    int_ack = 1; nxt(); int_ack = 0;

    // R1: reset restores default frequency
    cfg[5:3] = 3'b001; nxt(); nxt();
    chk("R10 freq code 001 again", freq_sel, 1);
    rst_n = 0; nxt();
    chk("R1 reset default frequency", freq_sel, 0);
    rst_n = 1; repeat (4) nxt();
    finish_run();
  end

endmodule